// File: doc/BRIEF.md
# Vector Extension Prefix Decoder

This block sits at the front of an instruction decoder running in 64-bit mode. Instruction bytes arrive one per clock, each qualified by a valid strobe. The block watches for the short (two-byte) and long (three-byte) forms of the compact vector-extension prefix. It keeps a short history of the legacy prefixes seen before that prefix. It then produces one decoded record per vector instruction, ending at the opcode byte.

The register fields in the prefix are stored inverted, and the block hands them out in true form. Fields that the short form does not carry are filled in with fixed values. A legacy prefix that must not precede the vector prefix raises an undefined-opcode fault, and so does an unknown opcode map. The fault is reported with the record; the offending prefix is not merged into it.

Parsing of ModRM, SIB, displacement and immediate bytes happens downstream, after the opcode.

Top module: `vxp_decoder`

## Requirements
- R1: With no prefix, the byte sequence C5h, b2, opcode, or the sequence C4h, b2, b3, opcode, gives `out_done` high for exactly the one cycle after the clock edge that accepts the opcode byte. `out_opcode` then holds that opcode byte.
- R2: `out_vsrc` is the bitwise complement of the 4-bit register field. That field is b2[6:3] in the short form and b3[6:3] in the long form.
- R3: `out_rext` is ~b2[7] in both forms. In the long form `out_xext` is ~b2[6] and `out_bext` is ~b2[5]. In the short form both are 0.
- R4: `out_wbit` equals b3[7] unchanged in the long form and is 0 in the short form.
- R5: `out_len256` equals the length bit. That bit is b2[2] in the short form and b3[2] in the long form; 1 means 256-bit and 0 means 128-bit.
- R6: `out_simd` equals the 2-bit implied-prefix field, b2[1:0] (short) or b3[1:0] (long). Its codes are 00 none, 01 66h, 10 F3h, 11 F2h.
- R7: `out_map` is 1 (0Fh escape) in the short form. In the long form it is b2[1:0] when b2[4:0] is 1 (0Fh), 2 (0F38h) or 3 (0F3Ah).
- R8: If any of F0h, 66h, F2h, F3h or 40h..4Fh is accepted before the C4h/C5h byte of the same instruction, `out_fault` is 1 with the record.
- R9: In the long form, a b2[4:0] value outside 1..3 sets `out_fault` and gives `out_map` = 0.
- R10: The prefixes 26h, 2Eh, 36h, 3Eh, 64h, 65h and 67h before the vector prefix are accepted and do not set `out_fault`.
- R11: A byte before the vector prefix that is neither a prefix nor C4h/C5h discards the prefix history and produces no `out_done`. Cycles with `in_valid` low change nothing.
- R12: The prefix history is cleared after each record, so a fault does not carry into the next instruction.
- R13: After reset, `out_done` and `out_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | `in_byte` carries an instruction byte this cycle |
| in_byte | input | 8 | Instruction byte |
| out_done | output | 1 | One-cycle pulse: record below is valid |
| out_vsrc | output | 4 | Extra source register index, true form |
| out_len256 | output | 1 | 1 = 256-bit vector, 0 = 128-bit |
| out_rext | output | 1 | ModRM reg extension bit, true form |
| out_xext | output | 1 | SIB index extension bit, true form |
| out_bext | output | 1 | Base/rm extension bit, true form |
| out_wbit | output | 1 | W bit as encoded |
| out_simd | output | 2 | Implied SIMD prefix code |
| out_map | output | 2 | Opcode map: 1=0Fh, 2=0F38h, 3=0F3Ah, 0=invalid |
| out_opcode | output | 8 | Opcode byte |
| out_fault | output | 1 | Undefined-opcode fault |

## Verification
The assertions assume that the upstream fetch presents one instruction's bytes in order and that `in_byte` is meaningful only while `in_valid` is high. They also assume that a new instruction begins right after a record or after a discarded byte. The stimulus keeps to this. Every instruction is driven whole, idle gaps appear only between bytes with `in_valid` low, and each record is checked before the next instruction's first byte. Field sweeps cover every second-byte value in both forms and a spread of third-byte values. Prefix checks cover each legacy prefix value singly and in pairs.

// File: rtl/vxp_pkg.sv
package vxp_pkg;
  localparam int BYTE_W  = 8;
  localparam int REG_W   = 4;
  localparam int MMAP_W  = 5;
  localparam int PP_W    = 2;

  localparam logic [BYTE_W-1:0] LEAD_SHORT = 8'hC5;
  localparam logic [BYTE_W-1:0] LEAD_LONG  = 8'hC4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PREFIX, ST_SHORT_B2, ST_LONG_B2, ST_LONG_B3, ST_OPCODE
  } vxp_state_e;

  // Prefixes that are forbidden ahead of the vector prefix
  function automatic logic is_fault_pfx(input logic [BYTE_W-1:0] b);
    return (b == 8'hF0) || (b == 8'h66) || (b == 8'hF2) || (b == 8'hF3) ||
           (b[7:4] == 4'h4);
  endfunction

  // Prefixes tolerated ahead of the vector prefix
  function automatic logic is_neutral_pfx(input logic [BYTE_W-1:0] b);
    return (b == 8'h26) || (b == 8'h2E) || (b == 8'h36) || (b == 8'h3E) ||
           (b == 8'h64) || (b == 8'h65) || (b == 8'h67);
  endfunction
endpackage

// File: rtl/vxp_prefix_track.sv
module vxp_prefix_track
  import vxp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              clr,
  input  logic [BYTE_W-1:0] din,
  output logic              pfx_bad
);
  logic bad_q, bad_d, bad_en;

  always_comb begin
    bad_en = clr || (acc && is_fault_pfx(din));
    bad_d  = clr ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bad_q <= 1'b0;
    else if (bad_en) bad_q <= bad_d;
  end

  assign pfx_bad = bad_q;

  // R8
  bad_pfx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !clr && is_fault_pfx(din)) |=> pfx_bad);

  // R12
  hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pfx_bad);
endmodule

// File: rtl/vxp_field_cap.sv
module vxp_field_cap
  import vxp_pkg::*;
#(
  parameter int NUM_MAPS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_s2,
  input  logic              cap_l2,
  input  logic              cap_l3,
  input  logic [BYTE_W-1:0] din,
  output logic [REG_W-1:0]  vsrc,
  output logic              len256,
  output logic              rext,
  output logic              xext,
  output logic              bext,
  output logic              wbit,
  output logic [PP_W-1:0]   simd,
  output logic [1:0]        map,
  output logic              map_bad
);
  // stored in encoded (inverted) form
  logic             r_n_q, x_n_q, b_n_q, w_q, l_q;
  logic [REG_W-1:0] v_n_q;
  logic [PP_W-1:0]  pp_q;
  logic [MMAP_W-1:0] mm_q;

  logic             r_n_d, x_n_d, b_n_d, w_d, l_d;
  logic [REG_W-1:0] v_n_d;
  logic [PP_W-1:0]  pp_d;
  logic [MMAP_W-1:0] mm_d;
  logic             ext_en, tail_en;

  always_comb begin
    ext_en  = cap_s2 || cap_l2;
    tail_en = cap_s2 || cap_l3;
    r_n_d   = din[7];
    x_n_d   = cap_s2 ? 1'b1 : din[6];
    b_n_d   = cap_s2 ? 1'b1 : din[5];
    mm_d    = cap_s2 ? MMAP_W'(1) : din[4:0];
    w_d     = cap_s2 ? 1'b0 : din[7];
    v_n_d   = din[6:3];
    l_d     = din[2];
    pp_d    = din[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_n_q <= 1'b1;
      x_n_q <= 1'b1;
      b_n_q <= 1'b1;
      mm_q  <= '0;
    end else if (ext_en) begin
      r_n_q <= r_n_d;
      x_n_q <= x_n_d;
      b_n_q <= b_n_d;
      mm_q  <= mm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q   <= 1'b0;
      v_n_q <= '1;
      l_q   <= 1'b0;
      pp_q  <= '0;
    end else if (tail_en) begin
      w_q   <= w_d;
      v_n_q <= v_n_d;
      l_q   <= l_d;
      pp_q  <= pp_d;
    end
  end

  logic map_ok;
  always_comb begin
    map_ok  = (mm_q >= MMAP_W'(1)) && (mm_q <= MMAP_W'(NUM_MAPS));
    map_bad = !map_ok;
    map     = map_ok ? mm_q[1:0] : 2'd0;
    vsrc    = ~v_n_q;
    rext    = ~r_n_q;
    xext    = ~x_n_q;
    bext    = ~b_n_q;
    wbit    = w_q;
    len256  = l_q;
    simd    = pp_q;
  end

  // R3
  short_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_s2 |=> (!xext && !bext && !wbit && map == 2'd1));
endmodule

// File: rtl/vxp_decoder.sv
module vxp_decoder
  import vxp_pkg::*;
#(
  parameter int NUM_MAPS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        out_done,
  output logic [3:0]  out_vsrc,
  output logic        out_len256,
  output logic        out_rext,
  output logic        out_xext,
  output logic        out_bext,
  output logic        out_wbit,
  output logic [1:0]  out_simd,
  output logic [1:0]  out_map,
  output logic [7:0]  out_opcode,
  output logic        out_fault
);
  vxp_state_e state_q, state_d;
  logic pfx_acc, hist_clr, cap_s2, cap_l2, cap_l3, op_acc;
  logic pfx_bad, map_bad;
  logic in_head;

  always_comb begin
    state_d  = state_q;
    pfx_acc  = 1'b0;
    hist_clr = 1'b0;
    cap_s2   = 1'b0;
    cap_l2   = 1'b0;
    cap_l3   = 1'b0;
    op_acc   = 1'b0;
    in_head  = (state_q == ST_IDLE) || (state_q == ST_PREFIX);
    if (in_valid) begin
      unique case (state_q)
        ST_IDLE, ST_PREFIX: begin
          if (in_byte == LEAD_SHORT)      state_d = ST_SHORT_B2;
          else if (in_byte == LEAD_LONG)  state_d = ST_LONG_B2;
          else if (is_fault_pfx(in_byte) || is_neutral_pfx(in_byte)) begin
            pfx_acc = 1'b1;
            state_d = ST_PREFIX;
          end else begin
            hist_clr = 1'b1;
            state_d  = ST_IDLE;
          end
        end
        ST_SHORT_B2: begin cap_s2 = 1'b1; state_d = ST_OPCODE; end
        ST_LONG_B2:  begin cap_l2 = 1'b1; state_d = ST_LONG_B3; end
        ST_LONG_B3:  begin cap_l3 = 1'b1; state_d = ST_OPCODE; end
        ST_OPCODE: begin
          op_acc   = 1'b1;
          hist_clr = 1'b1;
          state_d  = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_IDLE;
    else if (in_valid) state_q <= state_d;
  end

  vxp_prefix_track u_track (
    .clk(clk), .rst_n(rst_n), .acc(pfx_acc), .clr(hist_clr),
    .din(in_byte), .pfx_bad(pfx_bad)
  );

  vxp_field_cap #(.NUM_MAPS(NUM_MAPS)) u_fields (
    .clk(clk), .rst_n(rst_n), .cap_s2(cap_s2), .cap_l2(cap_l2),
    .cap_l3(cap_l3), .din(in_byte), .vsrc(out_vsrc), .len256(out_len256),
    .rext(out_rext), .xext(out_xext), .bext(out_bext), .wbit(out_wbit),
    .simd(out_simd), .map(out_map), .map_bad(map_bad)
  );

  logic       done_q, fault_q;
  logic [7:0] opc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= op_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q   <= '0;
      fault_q <= 1'b0;
    end else if (op_acc) begin
      opc_q   <= in_byte;
      fault_q <= pfx_bad || map_bad;
    end
  end

  assign out_done   = done_q;
  assign out_opcode = opc_q;
  assign out_fault  = fault_q;

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(state_q));

  // R9
  map_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && map_bad) |-> (out_fault && out_map == 2'd0));

  // R12
  head_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (in_head && !pfx_bad));
endmodule

// File: tb/vxp_decoder_tb_top.sv
module vxp_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_done, out_len256, out_rext, out_xext, out_bext, out_wbit, out_fault;
  logic [3:0] out_vsrc;
  logic [1:0] out_simd, out_map;
  logic [7:0] out_opcode;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vxp_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_done(out_done), .out_vsrc(out_vsrc), .out_len256(out_len256),
    .out_rext(out_rext), .out_xext(out_xext), .out_bext(out_bext),
    .out_wbit(out_wbit), .out_simd(out_simd), .out_map(out_map),
    .out_opcode(out_opcode), .out_fault(out_fault)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic push(input logic [7:0] b, input bit gap);
    if (gap) begin
      @(negedge clk); in_valid = 1'b0; in_byte = 8'hFF;
      @(negedge clk); @(negedge clk);
    end
    @(negedge clk); in_valid = 1'b1; in_byte = b;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] got();
    return {out_done, out_vsrc, out_len256, out_rext, out_xext, out_bext,
            out_wbit, out_simd, out_map, out_opcode, out_fault};
  endfunction

  function automatic logic [23:0] exp_short(input logic [7:0] b2, input logic [7:0] op,
                                            input logic f);
    return {1'b1, ~b2[6:3], b2[2], ~b2[7], 1'b0, 1'b0, 1'b0, b2[1:0], 2'd1, op, f};
  endfunction

  function automatic logic [23:0] exp_long(input logic [7:0] b2, input logic [7:0] b3,
                                           input logic [7:0] op, input logic f);
    logic ok;
    ok = (b2[4:0] >= 5'd1) && (b2[4:0] <= 5'd3);
    return {1'b1, ~b3[6:3], b3[2], ~b2[7], ~b2[6], ~b2[5], b3[7], b3[1:0],
            ok ? b2[1:0] : 2'd0, op, f | !ok};
  endfunction

  task automatic do_short(input logic [7:0] b2, input logic [7:0] op, input bit gap);
    push(8'hC5, gap); push(b2, gap); push(op, gap);
  endtask

  task automatic do_long(input logic [7:0] b2, input logic [7:0] b3,
                         input logic [7:0] op, input bit gap);
    push(8'hC4, gap); push(b2, gap); push(b3, gap); push(op, gap);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R13 reset state
    check("R13", {22'd0, out_done, out_fault}, 24'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2 R3 R5 R6 R7: short-form sweep of every second byte
    for (int i = 0; i < 256; i++) begin
      do_short(8'(i), 8'(i ^ 8'h5A), (i % 37) == 0);
      check("R1/R2/R3/R5/R6/R7 short", got(), exp_short(8'(i), 8'(i ^ 8'h5A), 1'b0));
    end

    // R4 R9: long-form sweep, every b2 against sixteen b3 values
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 16; j++) begin
        do_long(8'(i), 8'(j * 17), 8'(i + j), (j == 5));
        check("R1/R2/R3/R4/R7/R9 long", got(), exp_long(8'(i), 8'(j * 17), 8'(i + j), 1'b0));
      end
    end

    // R8: each forbidden prefix, both forms, followed by a clean record (R12)
    for (int p = 0; p < 256; p++) begin
      if (p == 'hF0 || p == 'h66 || p == 'hF2 || p == 'hF3 || (p >= 'h40 && p <= 'h4F)) begin
        push(8'(p), 1'b0);
        do_short(8'hF9, 8'h10, 1'b0);
        check("R8 short", got(), exp_short(8'hF9, 8'h10, 1'b1));
        push(8'(p), 1'b1);
        push(8'h26, 1'b0);
        do_long(8'hE2, 8'h7D, 8'h99, 1'b0);
        check("R8 long", got(), exp_long(8'hE2, 8'h7D, 8'h99, 1'b1));
        do_short(8'hF9, 8'h11, 1'b0);
        check("R12 cleared", got(), exp_short(8'hF9, 8'h11, 1'b0));
      end
    end

    // R10: tolerated prefixes, singly and in pairs
    begin
      logic [7:0] okp [7] = '{8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'h67};
      for (int k = 0; k < 7; k++) begin
        push(okp[k], 1'b0);
        push(okp[(k + 3) % 7], 1'b0);
        do_long(8'hE1, 8'h05, 8'h58, 1'b0);
        check("R10", got(), exp_long(8'hE1, 8'h05, 8'h58, 1'b0));
        push(okp[k], 1'b0);
        push(8'hF2, 1'b0);
        do_short(8'hC0, 8'h2A, 1'b0);
        check("R10/R8 mixed", got(), exp_short(8'hC0, 8'h2A, 1'b1));
      end
    end

    // R11: non-prefix byte discards history and produces no record
    push(8'h66, 1'b0);
    push(8'h90, 1'b0);
    check("R11 no done", {23'd0, out_done}, 24'd0);
    do_short(8'h78, 8'h3C, 1'b0);
    check("R11 history dropped", got(), exp_short(8'h78, 8'h3C, 1'b0));
    push(8'hF0, 1'b0);
    push(8'h0F, 1'b1);
    do_long(8'h63, 8'hFF, 8'hA5, 1'b1);
    check("R11 with stalls", got(), exp_long(8'h63, 8'hFF, 8'hA5, 1'b0));

    // R1: done lasts one cycle
    @(posedge clk); #1;
    check("R1 pulse", {23'd0, out_done}, 24'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule